// File: doc/BRIEF.md
# Priority Pin Assignment Crossbar

This block decides which digital peripheral signal drives each of 40 general-purpose pins. The pins form five ports of eight bits and are numbered linearly: pin index = port × 8 + bit. The peripheral signals sit in one fixed priority list. Each signal that is switched on takes the lowest-numbered pin that still exists, is not skipped, and has not gone to a signal higher in the list.

Firmware-style configuration inputs choose the signals. These are a global routing enable, a vector of group enables, two channel-count fields for the capture/compare banks, a per-pin skip mask and a package-size code. A pin is skipped when something outside the crossbar drives it directly, for example an analog input, a voltage reference or a crystal. The block has two kinds of output. Pin-side outputs tell each pad which signal it carries. Signal-side outputs tell each peripheral which pin it landed on. All outputs are registered.

Top module: `pin_xbar`

## Requirements
- R1: While `rst_i` is high, and after reset until the first configuration is captured, every pin reports the GPIO code 63 and every signal reports valid 0 with pin field 0.
- R2: When `route_en_i` is 0, the next registered result shows every pin as GPIO (63) and no signal as valid, whatever the other inputs are.
- R3: Signal indices follow the priority list: 0 UART0 TX, 1 UART0 RX, 2 CAN TX, 3 CAN RX, 4 SCK, 5 MISO, 6 MOSI, 7 NSS, 8 SDA, 9 SCL, 10 CP0, 11 CP0A, 12 CP1, 13 CP1A, 14 SYSCLK, 15–20 CEX0–CEX5, 21 ECI, 22 T0, 23 T1, 24 LIN TX, 25 LIN RX, 26 UART1 TX, 27 UART1 RX, 28 CP2, 29 CP2A, 30–35 CEX6–CEX11, 36 ECI1, 37 T4, 38 T4EX, 39 T5, 40 T5EX. The n-th requested signal in index order gets the n-th usable pin in ascending pin order.
- R4: A pin whose `skip_i` bit is 1 is never assigned. The search passes over it to the next pin.
- R5: The `grp_en_i` bits are, from bit 0 up: UART0, CAN, SPI, NSS, SMBus, CP0, CP0A, CP1, CP1A, SYSCLK, ECI, T0, T1, LIN, UART1, CP2, CP2A, ECI1, T4, T4EX, T5, T5EX. A UART, CAN, LIN or SMBus bit requests both of its signals. The SPI bit requests SCK, MISO and MOSI. The NSS bit requests NSS only while the SPI bit is also 1.
- R6: A channel-count field N requests the first N capture/compare outputs of its bank. `pca0_cnt_i` controls CEX0–CEX5 and `pca1_cnt_i` controls CEX6–CEX11. Values 6 and 7 both request all six.
- R7: `pkg_sel_i` 0 makes pins 0–39 usable. 1 makes pins 0–32 usable. 2 and 3 make pins 0–24 usable. A pin beyond the limit is never assigned.
- R8: A requested signal that finds no usable pin left reports valid 0 and pin field 0. The signals before it keep their pins, so a pair can be split when the pins run out.
- R9: Outputs change only at a clock edge and show the inputs sampled at that edge. Between edges they hold the previous result.
- R10: For every valid signal s, the pin it reports carries index s. Every pin that is not assigned reports 63.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| route_en_i | input | 1 | Global crossbar enable |
| grp_en_i | input | 22 | Peripheral group enables (layout in R5) |
| pca0_cnt_i | input | 3 | Number of CEX0–CEX5 outputs to route |
| pca1_cnt_i | input | 3 | Number of CEX6–CEX11 outputs to route |
| pkg_sel_i | input | 2 | Package-size code (R7) |
| skip_i | input | 40 | Per-pin skip mask, bit = pin index |
| pin_sig_o | output | 240 | Per pin, 6-bit signal index or 63 for GPIO; pin p in bits [6p+5:6p] |
| sig_pin_o | output | 246 | Per signal, 6-bit pin index; signal s in bits [6s+5:6s] |
| sig_vld_o | output | 41 | Per signal, 1 when it holds a pin |

## Verification
The hardest case to reach is a requested signal that sits right at the edge where the usable pins run out. Three things must line up for it: the package limit, the skip mask and the number of requested signals before it. Only then does a two-signal peripheral end up split, or a late signal get its pin from a gap that a skipped pin left. The stimulus requests every group with full channel counts, which makes 41 signals for at most 40 pins. It then walks one skip bit across every pin and steps through each package code, so the end point moves across the list. Several hundred pseudo-random mixes of enables, skips and packages then land on many other end points.

// File: rtl/xbar_pkg.sv
package xbar_pkg;

    localparam int PORT_CNT  = 5;
    localparam int PORT_BITS = 8;
    localparam int PIN_CNT   = PORT_CNT * PORT_BITS;
    localparam int PCA_CH    = 6;
    localparam int CNT_W     = 3;
    localparam int GRP_CNT   = 22;
    localparam int SIG_CNT   = 41;

    localparam int SIG_W  = $clog2(SIG_CNT + 1);
    localparam int PIN_W  = $clog2(PIN_CNT);
    localparam int RANK_W = $clog2(SIG_CNT + PIN_CNT + 1);

    localparam logic [SIG_W-1:0] GPIO_CODE = '1;

    // usable pin counts per package size
    localparam int PINS_LARGE = PIN_CNT;
    localparam int PINS_MID   = 33;
    localparam int PINS_SMALL = 25;

    typedef enum logic [1:0] {
        PKG_LARGE = 2'd0,
        PKG_MID   = 2'd1,
        PKG_SMALL = 2'd2,
        PKG_ALT   = 2'd3
    } pkg_sel_e;

    // group-enable bit positions
    localparam int G_UART0 = 0;
    localparam int G_CAN   = 1;
    localparam int G_SPI   = 2;
    localparam int G_NSS   = 3;
    localparam int G_SMB   = 4;
    localparam int G_CP0   = 5;
    localparam int G_CP0A  = 6;
    localparam int G_CP1   = 7;
    localparam int G_CP1A  = 8;
    localparam int G_SYSCK = 9;
    localparam int G_ECI   = 10;
    localparam int G_T0    = 11;
    localparam int G_T1    = 12;
    localparam int G_LIN   = 13;
    localparam int G_UART1 = 14;
    localparam int G_CP2   = 15;
    localparam int G_CP2A  = 16;
    localparam int G_ECI1  = 17;
    localparam int G_T4    = 18;
    localparam int G_T4EX  = 19;
    localparam int G_T5    = 20;
    localparam int G_T5EX  = 21;

    // signal index anchors (priority order)
    localparam int S_UART0 = 0;
    localparam int S_CAN   = 2;
    localparam int S_SPI   = 4;
    localparam int S_NSS   = 7;
    localparam int S_SMB   = 8;
    localparam int S_CP0   = 10;
    localparam int S_SYSCK = 14;
    localparam int S_CEXA  = 15;
    localparam int S_ECI   = 21;
    localparam int S_T0    = 22;
    localparam int S_LIN   = 24;
    localparam int S_UART1 = 26;
    localparam int S_CP2   = 28;
    localparam int S_CEXB  = 30;
    localparam int S_ECI1  = 36;
    localparam int S_T4    = 37;

    typedef struct packed {
        logic             vld;
        logic [PIN_W-1:0] pin;
    } sig_slot_t;

    function automatic logic [PIN_W:0] pin_limit(input pkg_sel_e sel);
        case (sel)
            PKG_LARGE: return (PIN_W+1)'(PINS_LARGE);
            PKG_MID:   return (PIN_W+1)'(PINS_MID);
            default:   return (PIN_W+1)'(PINS_SMALL);
        endcase
    endfunction

    function automatic logic [PCA_CH-1:0] chan_mask(input logic [CNT_W-1:0] cnt);
        logic [PCA_CH-1:0] m;
        for (int i = 0; i < PCA_CH; i++) begin
            m[i] = (CNT_W'(i) < cnt);
        end
        return m;
    endfunction

endpackage

// File: rtl/xbar_req_decode.sv
module xbar_req_decode
    import xbar_pkg::*;
(
    input  logic                 route_en,
    input  logic [GRP_CNT-1:0]   grp_en,
    input  logic [CNT_W-1:0]     cnt_a,
    input  logic [CNT_W-1:0]     cnt_b,
    output logic [SIG_CNT-1:0]   req
);

    logic [SIG_CNT-1:0] raw;
    logic [PCA_CH-1:0]  bank_a;
    logic [PCA_CH-1:0]  bank_b;

    assign bank_a = chan_mask(cnt_a);
    assign bank_b = chan_mask(cnt_b);

    always_comb begin
        raw = '0;
        raw[S_UART0 +: 2]       = {2{grp_en[G_UART0]}};
        raw[S_CAN   +: 2]       = {2{grp_en[G_CAN]}};
        raw[S_SPI   +: 3]       = {3{grp_en[G_SPI]}};
        raw[S_NSS]              = grp_en[G_SPI] & grp_en[G_NSS];
        raw[S_SMB   +: 2]       = {2{grp_en[G_SMB]}};
        raw[S_CP0   +: 4]       = grp_en[G_CP1A:G_CP0];
        raw[S_SYSCK]            = grp_en[G_SYSCK];
        raw[S_CEXA  +: PCA_CH]  = bank_a;
        raw[S_ECI   +: 3]       = grp_en[G_T1:G_ECI];
        raw[S_LIN   +: 2]       = {2{grp_en[G_LIN]}};
        raw[S_UART1 +: 2]       = {2{grp_en[G_UART1]}};
        raw[S_CP2   +: 2]       = grp_en[G_CP2A:G_CP2];
        raw[S_CEXB  +: PCA_CH]  = bank_b;
        raw[S_ECI1]             = grp_en[G_ECI1];
        raw[S_T4    +: 4]       = grp_en[G_T5EX:G_T4];
    end

    assign req = route_en ? raw : '0;

endmodule

// File: rtl/xbar_pin_mask.sv
module xbar_pin_mask
    import xbar_pkg::*;
(
    input  pkg_sel_e             pkg_sel,
    input  logic [PIN_CNT-1:0]   skip,
    output logic [PIN_CNT-1:0]   avail
);

    logic [PIN_W:0] limit;
    assign limit = pin_limit(pkg_sel);

    for (genvar p = 0; p < PIN_CNT; p++) begin : g_pin
        assign avail[p] = ~skip[p] & ((PIN_W+1)'(p) < limit);
    end

endmodule

// File: rtl/xbar_rank_match.sv
module xbar_rank_match
    import xbar_pkg::*;
(
    input  logic [SIG_CNT-1:0]                req,
    input  logic [PIN_CNT-1:0]                avail,
    output logic [PIN_CNT-1:0][SIG_W-1:0]     pin_sig,
    output sig_slot_t [SIG_CNT-1:0]           sig_slot
);

    logic [RANK_W-1:0] sig_rank [SIG_CNT];
    logic [RANK_W-1:0] pin_rank [PIN_CNT];

    // exclusive prefix counts: how many requested signals / usable pins precede
    always_comb begin
        logic [RANK_W-1:0] acc;
        acc = '0;
        for (int s = 0; s < SIG_CNT; s++) begin
            sig_rank[s] = acc;
            acc = acc + RANK_W'(req[s]);
        end
    end

    always_comb begin
        logic [RANK_W-1:0] acc;
        acc = '0;
        for (int p = 0; p < PIN_CNT; p++) begin
            pin_rank[p] = acc;
            acc = acc + RANK_W'(avail[p]);
        end
    end

    // a signal meets the usable pin of equal rank
    always_comb begin
        for (int p = 0; p < PIN_CNT; p++) begin
            pin_sig[p] = GPIO_CODE;
        end
        for (int s = 0; s < SIG_CNT; s++) begin
            sig_slot[s] = '0;
        end
        for (int s = 0; s < SIG_CNT; s++) begin
            for (int p = 0; p < PIN_CNT; p++) begin
                if (req[s] && avail[p] && (pin_rank[p] == sig_rank[s])) begin
                    pin_sig[p]      = SIG_W'(s);
                    sig_slot[s].vld = 1'b1;
                    sig_slot[s].pin = PIN_W'(p);
                end
            end
        end
    end

endmodule

// File: rtl/pin_xbar.sv
module pin_xbar
    import xbar_pkg::*;
(
    input  logic                              clk_i,
    input  logic                              rst_i,
    input  logic                              route_en_i,
    input  logic [GRP_CNT-1:0]                grp_en_i,
    input  logic [CNT_W-1:0]                  pca0_cnt_i,
    input  logic [CNT_W-1:0]                  pca1_cnt_i,
    input  logic [1:0]                        pkg_sel_i,
    input  logic [PIN_CNT-1:0]                skip_i,
    output logic [PIN_CNT-1:0][SIG_W-1:0]     pin_sig_o,
    output logic [SIG_CNT-1:0][PIN_W-1:0]     sig_pin_o,
    output logic [SIG_CNT-1:0]                sig_vld_o
);

    logic [SIG_CNT-1:0]            req;
    logic [PIN_CNT-1:0]            avail;
    logic [PIN_CNT-1:0][SIG_W-1:0] pin_sig_d;
    sig_slot_t [SIG_CNT-1:0]       slot_d;
    sig_slot_t [SIG_CNT-1:0]       slot_q;

    xbar_req_decode u_req (
        .route_en (route_en_i),
        .grp_en   (grp_en_i),
        .cnt_a    (pca0_cnt_i),
        .cnt_b    (pca1_cnt_i),
        .req      (req)
    );

    xbar_pin_mask u_mask (
        .pkg_sel  (pkg_sel_e'(pkg_sel_i)),
        .skip     (skip_i),
        .avail    (avail)
    );

    xbar_rank_match u_match (
        .req      (req),
        .avail    (avail),
        .pin_sig  (pin_sig_d),
        .sig_slot (slot_d)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            pin_sig_o <= {PIN_CNT{GPIO_CODE}};
            slot_q    <= '0;
        end else begin
            pin_sig_o <= pin_sig_d;
            slot_q    <= slot_d;
        end
    end

    for (genvar s = 0; s < SIG_CNT; s++) begin : g_out
        assign sig_pin_o[s] = slot_q[s].pin;
        assign sig_vld_o[s] = slot_q[s].vld;
    end

endmodule

// File: rtl/pin_xbar_chk.sv
module pin_xbar_chk
    import xbar_pkg::*;
(
    input  logic                              clk_i,
    input  logic                              rst_i,
    input  logic                              route_en_i,
    input  logic [1:0]                        pkg_sel_i,
    input  logic [PIN_CNT-1:0]                skip_i,
    input  logic [PIN_CNT-1:0][SIG_W-1:0]     pin_sig_o,
    input  logic [SIG_CNT-1:0][PIN_W-1:0]     sig_pin_o,
    input  logic [SIG_CNT-1:0]                sig_vld_o
);

    a_r2_off_no_valid: assert property (@(posedge clk_i) disable iff (rst_i)
        !$past(route_en_i) |-> (sig_vld_o == '0))
        else $error("R2: signal valid while routing disabled");

    a_r8_pair_order: assert property (@(posedge clk_i) disable iff (rst_i)
        (!sig_vld_o[1] || sig_vld_o[0]) && (!sig_vld_o[3] || sig_vld_o[2]) &&
        (!sig_vld_o[9] || sig_vld_o[8]) && (!sig_vld_o[25] || sig_vld_o[24]) &&
        (!sig_vld_o[27] || sig_vld_o[26]))
        else $error("R8: second half of a pair placed without the first");

    for (genvar p = 0; p < PIN_CNT; p++) begin : g_pin
        a_r4_skip_free: assert property (@(posedge clk_i) disable iff (rst_i)
            $past(skip_i[p]) |-> (pin_sig_o[p] == GPIO_CODE))
            else $error("R4: skipped pin %0d assigned", p);

        a_r7_absent_free: assert property (@(posedge clk_i) disable iff (rst_i)
            ((PIN_W+1)'(p) >= pin_limit(pkg_sel_e'($past(pkg_sel_i)))) |->
            (pin_sig_o[p] == GPIO_CODE))
            else $error("R7: absent pin %0d assigned", p);
    end

    for (genvar s = 0; s < SIG_CNT; s++) begin : g_sig
        a_r10_pin_agrees: assert property (@(posedge clk_i) disable iff (rst_i)
            sig_vld_o[s] |-> (pin_sig_o[sig_pin_o[s]] == SIG_W'(s)))
            else $error("R10: signal %0d and its pin disagree", s);

        a_r8_invalid_zero: assert property (@(posedge clk_i) disable iff (rst_i)
            !sig_vld_o[s] |-> (sig_pin_o[s] == '0))
            else $error("R8: invalid signal %0d has nonzero pin", s);
    end

endmodule

bind pin_xbar pin_xbar_chk u_chk (.*);

// File: tb/sim_pin_xbar.sv
module sim_pin_xbar;
    import xbar_pkg::*;

    logic                          clk = 1'b0;
    logic                          rst;
    logic                          route_en;
    logic [GRP_CNT-1:0]            grp;
    logic [CNT_W-1:0]              c0, c1;
    logic [1:0]                    pkg;
    logic [PIN_CNT-1:0]            skip;
    logic [PIN_CNT-1:0][SIG_W-1:0] pin_sig;
    logic [SIG_CNT-1:0][PIN_W-1:0] sig_pin;
    logic [SIG_CNT-1:0]            sig_vld;

    int  n_checks = 0;
    int  n_errs   = 0;
    bit  done     = 0;
    int  exp_pin [PIN_CNT];
    int  exp_sp  [SIG_CNT];
    bit  exp_v   [SIG_CNT];

    always #4 clk = ~clk;

    pin_xbar u0 (
        .clk_i(clk), .rst_i(rst), .route_en_i(route_en), .grp_en_i(grp),
        .pca0_cnt_i(c0), .pca1_cnt_i(c1), .pkg_sel_i(pkg), .skip_i(skip),
        .pin_sig_o(pin_sig), .sig_pin_o(sig_pin), .sig_vld_o(sig_vld)
    );

    // reference: expand groups by size, then scan pins with a cursor
    task automatic model();
        bit req [SIG_CNT];
        int idx = 0;
        int lim = (pkg == 2'd0) ? 40 : (pkg == 2'd1) ? 33 : 25;
        int p = 0;
        for (int g = 0; g < GRP_CNT; g++) begin
            int sz = (g == 0 || g == 1 || g == 4 || g == 13 || g == 14) ? 2 :
                     (g == 2) ? 3 : 1;
            bit en = route_en && grp[g] && (g != 3 || grp[2]);
            if (g == 10 || g == 17) begin
                int n = (g == 10) ? int'(c0) : int'(c1);
                if (n > 6) n = 6;
                for (int k = 0; k < 6; k++) begin
                    req[idx] = route_en && (k < n);
                    idx++;
                end
            end
            for (int k = 0; k < sz; k++) begin
                req[idx] = en;
                idx++;
            end
        end
        for (int q = 0; q < PIN_CNT; q++) exp_pin[q] = 63;
        for (int s = 0; s < SIG_CNT; s++) begin
            exp_v[s] = 0;
            exp_sp[s] = 0;
            if (req[s]) begin
                while (p < lim && skip[p]) p++;
                if (p < lim) begin
                    exp_v[s] = 1;
                    exp_sp[s] = p;
                    exp_pin[p] = s;
                    p++;
                end
            end
        end
    endtask

    task automatic compare(input string tag);
        int bad = 0;
        for (int q = 0; q < PIN_CNT; q++) begin
            if (int'(pin_sig[q]) != exp_pin[q]) begin
                if (bad == 0)
                    $display("FAIL %s: pin %0d carries %0d, expected %0d",
                             tag, q, pin_sig[q], exp_pin[q]);
                bad++;
            end
        end
        for (int s = 0; s < SIG_CNT; s++) begin
            if (sig_vld[s] != exp_v[s] || int'(sig_pin[s]) != exp_sp[s]) begin
                if (bad == 0)
                    $display("FAIL %s: signal %0d got vld=%0d pin=%0d, expected vld=%0d pin=%0d",
                             tag, s, sig_vld[s], sig_pin[s], exp_v[s], exp_sp[s]);
                bad++;
            end
        end
        n_checks++;
        if (bad != 0) n_errs++;
    endtask

    task automatic step(input string tag);
        model();
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    function automatic logic [31:0] nxt(input logic [31:0] x);
        logic [31:0] y = x;
        y = y ^ (y << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        $display("FAIL watchdog: run did not complete, got timeout expected finish");
        n_checks++;
        n_errs++;
        finish_run();
    end

    initial begin
        logic [31:0] r = 32'h1234_5678;
        rst = 1'b1; route_en = 1'b1; grp = '1; c0 = 3'd6; c1 = 3'd6;
        pkg = 2'd0; skip = '0;
        repeat (3) @(negedge clk);
        // R1: reset holds all GPIO despite full request
        route_en = 1'b0;
        model();
        compare("R1 reset");
        rst = 1'b0;
        route_en = 1'b1;
        compare("R1 post-reset");

        // R9: hold between edges, update after edge
        grp = 22'h1; c0 = 0; c1 = 0;
        step("R9 first");
        grp = 22'h4;
        #1 compare("R9 hold");
        @(negedge clk);
        model();
        compare("R9 update");

        // R5: each group alone
        for (int g = 0; g < GRP_CNT; g++) begin
            grp = '0; grp[g] = 1'b1; c0 = 0; c1 = 0;
            step("R5 single group");
        end
        grp = 22'h8;
        step("R5 NSS without SPI");
        grp = 22'hC;
        step("R5 NSS with SPI");

        // R6: channel counts
        grp = 22'h1;
        for (int n = 0; n < 8; n++) begin
            c0 = 3'(n); c1 = 3'(7 - n);
            step("R6 channel count");
        end

        // R7, R8: everything requested on every package
        grp = '1; c0 = 3'd6; c1 = 3'd7; skip = '0;
        for (int k = 0; k < 4; k++) begin
            pkg = 2'(k);
            step("R7 R8 package exhaust");
        end

        // R4: one skipped pin at each position, full request
        pkg = 2'd0;
        for (int q = 0; q < PIN_CNT; q++) begin
            skip = '0; skip[q] = 1'b1;
            step("R4 walking skip");
        end
        skip = '1;
        step("R4 all skipped");

        // R2: routing disabled
        skip = '0; route_en = 1'b0;
        step("R2 disabled");
        route_en = 1'b1;
        step("R2 re-enabled");

        // R3, R10: pseudo-random mixes
        for (int t = 0; t < 400; t++) begin
            logic [31:0] a, b, c;
            r = nxt(r); a = r;
            r = nxt(r); b = r;
            r = nxt(r); c = r;
            grp      = a[21:0];
            c0       = a[24:22];
            c1       = a[27:25];
            pkg      = a[29:28];
            route_en = a[30] | a[31] | b[0];
            skip     = {b[15:8] & c[7:0], b[31:0] & c[31:0]};
            if (t[0]) skip = skip & {c[7:0], b};
            step("R3 R10 random mix");
        end

        finish_run();
    end

endmodule